// File: doc/BRIEF.md
# Master Clock Source Selector

This block decides which oscillator drives the system master clock. It can pick from four sources: an external crystal rated 1 to 24 MHz, an external user clock of up to 24 MHz, a 16 MHz fast internal RC and a 128 kHz slow internal RC. The fast RC feeds a prescaler that divides by 1, 2, 4 or 8. The block does not contain the oscillators or the glitch-free clock mux. It keeps the selection state, and the mux and the oscillator enables follow that state.

Firmware programs the block through one configuration write. The write carries a requested source, a prescaler code, one enable bit per oscillator and a fast-wakeup option. A requested switch waits until the target oscillator reports ready. Two hardware events take control away from firmware:
- A wakeup from halt, when the fast-wakeup option is set, selects the fast RC.
- A crystal failure falls back to the fast RC divided by 8.

The block also requests one flash wait state whenever the selected source runs faster than 16 MHz.

Top module: `mclk_src_sel`

## Requirements
- R1: `mclk_src` reports the active source with code 0 = fast RC, 1 = slow RC, 2 = crystal, 3 = user clock.
- R2: While reset is held and after it is released, `mclk_src` is 0, `rc_div_sel` is 3 (divide by 8), `osc_en` is 4'b0001 and `flash_ws` is 0.
- R3: The `cfg_div` codes 0, 1, 2 and 3 set `rc_div_sel` to 0, 1, 2 and 3 (divide by 1, 2, 4 and 8). Codes 4 to 7 saturate to 3. The new value appears in the cycle after an accepted write.
- R4: A write whose `cfg_src` differs from the active source makes that source pending. `mclk_src` takes the pending value in the cycle after the first clock edge with `osc_rdy[target]` high, and that edge must not carry an accepted write. A write that names the active source cancels the pending switch. A later write replaces the pending target.
- R5: An accepted write loads `osc_en` with `cfg_osc_en`, and forces on the bit of the active source and the bit of `cfg_src`. Firmware therefore cannot switch off the active oscillator.
- R6: When the fast-wakeup bit from the last accepted write is 1, `wake_evt` makes `mclk_src` 0 in the next cycle. It also cancels any pending switch, sets `osc_en[0]` and leaves `rc_div_sel` unchanged. When that bit is 0, `wake_evt` has no effect.
- R7: When the crystal is active or pending, `xtal_fail` causes the following in the next cycle: `mclk_src` becomes 0, `rc_div_sel` becomes 3, `osc_en[2]` is cleared, `osc_en[0]` is set and any pending switch is cancelled. When the crystal is neither active nor pending, `xtal_fail` has no effect.
- R8: A crystal failure takes priority over a wakeup, and a wakeup takes priority over a configuration write. A write in a cycle that is taken over is dropped completely.
- R9: `flash_ws` is 1 only when the active source runs above 16000 kHz. The crystal and the user clock use their parameter frequencies. The fast RC uses 16000 kHz divided by the prescaler. With the defaults (crystal 24000 kHz, user clock 12000 kHz), `flash_ws` is 1 only when the crystal is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Requested master source code |
| cfg_div | input | 3 | Fast RC prescaler code |
| cfg_osc_en | input | 4 | Oscillator enable bits, indexed by source code |
| cfg_fast_wake | input | 1 | Select fast RC on wakeup from halt |
| osc_rdy | input | 4 | Per-oscillator stable flags |
| wake_evt | input | 1 | Wakeup from halt or active-halt |
| xtal_fail | input | 1 | External crystal failure detected |
| mclk_src | output | 2 | Active master source code |
| rc_div_sel | output | 2 | Prescaler select, divide by 2^value |
| osc_en | output | 4 | Oscillator enables |
| flash_ws | output | 1 | One flash wait state requested |

## Verification
Directed sequences apply every prescaler code. This separates the four exact divide codes from the saturating ones. Other directed sequences switch to each external source with its ready flag first held low and then raised, so that a pending switch is distinguished from an immediate one. Crystal failure and wakeup are each applied once with the crystal or the option involved and once without, which shows that each event acts only when its condition holds. A failure that coincides with a write shows that the write is dropped. Seeded random traffic then mixes writes, ready flags, wakeups and failures, so that the event priorities and the pending-target replacement are exercised against a bench model of the requirements.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
   localparam int NUM_SRC = 4;
   localparam int SRC_W   = 2;

   typedef enum logic [SRC_W-1:0] {
      SRC_RC_FAST = 2'd0,
      SRC_RC_SLOW = 2'd1,
      SRC_XTAL    = 2'd2,
      SRC_EXT     = 2'd3
   } src_e;

   function automatic logic [NUM_SRC-1:0] src_bit(input src_e s);
      return NUM_SRC'(1) << s;
   endfunction
endpackage

// File: rtl/mclk_div_reg.sv
module mclk_div_reg #(
   parameter int CODE_W = 3,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   input  logic              force_slow,
   output logic [SEL_W-1:0]  sel
);
   localparam int MAX_SEL = (1 << SEL_W) - 1;

   logic [SEL_W-1:0] decoded;

   generate
      if (CODE_W > SEL_W) begin : g_saturate
         assign decoded = (code > CODE_W'(MAX_SEL)) ? SEL_W'(MAX_SEL)
                                                    : code[SEL_W-1:0];
      end else begin : g_direct
         assign decoded = SEL_W'(code);
      end
   endgenerate

   initial begin
      if (CODE_W < 1 || SEL_W < 1)
         $error("mclk_div_reg: widths must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          sel <= SEL_W'(MAX_SEL);
      else if (force_slow) sel <= SEL_W'(MAX_SEL);
      else if (load)       sel <= decoded;
   end

   // R3: out-of-range codes land on the slowest division
   a_r3_div_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !force_slow && code > CODE_W'(MAX_SEL)) |=> sel == SEL_W'(MAX_SEL));
   // R7: a fallback always selects the slowest division
   a_r7_slowest_div: assert property (@(posedge clk) disable iff (!rst_n)
      force_slow |=> sel == SEL_W'(MAX_SEL));
endmodule

// File: rtl/mclk_en_reg.sv
module mclk_en_reg #(
   parameter int              N      = 4,
   parameter logic [N-1:0]    RST_EN = N'(1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] wr_bits,
   input  logic [N-1:0] set_mask,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] en
);
   always_ff @(posedge clk) begin
      if (!rst_n)    en <= RST_EN;
      else if (load) en <= wr_bits | set_mask;
      else           en <= (en | set_mask) & ~clr_mask;
   end

   // R5: a forced bit survives the load
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((en & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/mclk_switch_fsm.sv
module mclk_switch_fsm
   import mclk_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_go,
   input  src_e               req_src,
   input  logic [NUM_SRC-1:0] rdy,
   input  logic               wake_hit,
   input  logic               xtal_fail,
   output logic               fail_hit,
   output src_e               active
);
   src_e act_q, tgt_q;
   logic pend_q;

   assign fail_hit = xtal_fail &&
                     (act_q == SRC_XTAL || (pend_q && tgt_q == SRC_XTAL));
   assign active   = act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= SRC_RC_FAST;
         tgt_q  <= SRC_RC_FAST;
         pend_q <= 1'b0;
      end else if (fail_hit || wake_hit) begin
         act_q  <= SRC_RC_FAST;
         pend_q <= 1'b0;
      end else if (req_go) begin
         tgt_q  <= req_src;
         pend_q <= (req_src != act_q);
      end else if (pend_q && rdy[tgt_q]) begin
         act_q  <= tgt_q;
         pend_q <= 1'b0;
      end
   end

   // R4: a move away from the fast RC only follows a ready pending target
   a_r4_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q != $past(act_q) && act_q != SRC_RC_FAST) |->
      ($past(pend_q) && $past(rdy[tgt_q]) && $past(tgt_q) == act_q));
   // R7: crystal failure returns to the fast RC with nothing pending
   a_r7_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      fail_hit |=> (act_q == SRC_RC_FAST && !pend_q));
   // R6: accepted wakeup selects the fast RC
   a_r6_wake_fast: assert property (@(posedge clk) disable iff (!rst_n)
      wake_hit |=> act_q == SRC_RC_FAST);
endmodule

// File: rtl/mclk_src_sel.sv
module mclk_src_sel
   import mclk_pkg::*;
#(
   parameter int XTAL_KHZ     = 24000,
   parameter int EXT_KHZ      = 12000,
   parameter int RC_FAST_KHZ  = 16000,
   parameter int RC_SLOW_KHZ  = 128,
   parameter int WS_LIMIT_KHZ = 16000,
   parameter int DIV_CODE_W   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_src,
   input  logic [DIV_CODE_W-1:0] cfg_div,
   input  logic [3:0]            cfg_osc_en,
   input  logic                  cfg_fast_wake,
   input  logic [3:0]            osc_rdy,
   input  logic                  wake_evt,
   input  logic                  xtal_fail,
   output logic [1:0]            mclk_src,
   output logic [1:0]            rc_div_sel,
   output logic [3:0]            osc_en,
   output logic                  flash_ws
);
   localparam int SEL_W = 2;

   initial begin
      if (XTAL_KHZ < 1000 || XTAL_KHZ > 24000)
         $error("mclk_src_sel: crystal rate out of range");
      if (EXT_KHZ < 1 || EXT_KHZ > 24000)
         $error("mclk_src_sel: user clock rate out of range");
   end

   src_e               active;
   logic               fail_hit, wake_hit, cfg_go, fast_wake_q;
   logic [NUM_SRC-1:0] set_mask, clr_mask, ws_src;

   assign wake_hit = wake_evt && fast_wake_q && !fail_hit;
   assign cfg_go   = cfg_we && !fail_hit && !wake_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)      fast_wake_q <= 1'b0;
      else if (cfg_go) fast_wake_q <= cfg_fast_wake;
   end

   mclk_switch_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_go    (cfg_go),
      .req_src   (src_e'(cfg_src)),
      .rdy       (osc_rdy),
      .wake_hit  (wake_hit),
      .xtal_fail (xtal_fail),
      .fail_hit  (fail_hit),
      .active    (active)
   );

   mclk_div_reg #(.CODE_W(DIV_CODE_W), .SEL_W(SEL_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cfg_go),
      .code       (cfg_div),
      .force_slow (fail_hit),
      .sel        (rc_div_sel)
   );

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (fail_hit) begin
         set_mask = src_bit(SRC_RC_FAST);
         clr_mask = src_bit(SRC_XTAL);
      end else if (wake_hit) begin
         set_mask = src_bit(SRC_RC_FAST);
      end else if (cfg_go) begin
         set_mask = src_bit(active) | src_bit(src_e'(cfg_src));
      end
   end

   mclk_en_reg #(.N(NUM_SRC), .RST_EN(NUM_SRC'(1))) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_go),
      .wr_bits  (cfg_osc_en),
      .set_mask (set_mask),
      .clr_mask (clr_mask),
      .en       (osc_en)
   );

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_ws
         if (s == int'(SRC_RC_FAST)) begin : g_fast
            assign ws_src[s] = (RC_FAST_KHZ >> rc_div_sel) > WS_LIMIT_KHZ;
         end else if (s == int'(SRC_RC_SLOW)) begin : g_slow
            assign ws_src[s] = RC_SLOW_KHZ > WS_LIMIT_KHZ;
         end else if (s == int'(SRC_XTAL)) begin : g_xtal
            assign ws_src[s] = XTAL_KHZ > WS_LIMIT_KHZ;
         end else begin : g_ext
            assign ws_src[s] = EXT_KHZ > WS_LIMIT_KHZ;
         end
      end
   endgenerate

   assign mclk_src = active;
   assign flash_ws = ws_src[active];

   // R5: the oscillator feeding the master clock is never disabled
   a_r5_active_on: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en[mclk_src]);
   // R9: with default rates only the crystal needs a wait state
   a_r9_ws_source: assert property (@(posedge clk) disable iff (!rst_n)
      flash_ws |-> (mclk_src == SRC_XTAL || mclk_src == SRC_EXT));
   // R8: a failure suppresses any write in the same cycle
   a_r8_fail_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_hit && cfg_we) |=> rc_div_sel == 2'd3);
endmodule

// File: tb/mclk_src_sel_tb.sv
module mclk_src_sel_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we, cfg_fast_wake, wake_evt, xtal_fail;
   logic [1:0] cfg_src;
   logic [2:0] cfg_div;
   logic [3:0] cfg_osc_en, osc_rdy;
   logic [1:0] mclk_src, rc_div_sel;
   logic [3:0] osc_en;
   logic       flash_ws;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model state
   int m_src, m_div, m_pt;
   logic [3:0] m_en;
   bit m_pv, m_fw;
   string ev_tag;

   always #2 clk = ~clk;

   mclk_src_sel u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
      .cfg_div(cfg_div), .cfg_osc_en(cfg_osc_en), .cfg_fast_wake(cfg_fast_wake),
      .osc_rdy(osc_rdy), .wake_evt(wake_evt), .xtal_fail(xtal_fail),
      .mclk_src(mclk_src), .rc_div_sel(rc_div_sel), .osc_en(osc_en),
      .flash_ws(flash_ws)
   );

   function automatic int dec_div(input logic [2:0] c);
      return (c > 3'd3) ? 3 : int'(c);
   endfunction

   function automatic bit exp_ws(input int s, input int d);
      if (s == 2) return 1'b1;            // 24000 kHz crystal
      if (s == 3) return 1'b0;            // 12000 kHz user clock
      if (s == 0) return (16000 >> d) > 16000;
      return 1'b0;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      check({ev_tag, " R1 source"}, int'(mclk_src), m_src);
      check("R3 prescaler", int'(rc_div_sel), m_div);
      check("R5 enables", int'(osc_en), int'(m_en));
      check("R9 wait state", int'(flash_ws), int'(exp_ws(m_src, m_div)));
   endtask

   task automatic idle();
      cfg_we = 0; wake_evt = 0; xtal_fail = 0;
   endtask

   task automatic wr(input int s, input int d, input logic [3:0] e, input bit fw);
      cfg_we = 1; cfg_src = 2'(s); cfg_div = 3'(d); cfg_osc_en = e; cfg_fast_wake = fw;
   endtask

   task automatic model_step();
      bit fh, wh, go;
      fh = xtal_fail && (m_src == 2 || (m_pv && m_pt == 2));
      wh = wake_evt && m_fw && !fh;
      go = cfg_we && !fh && !wh;
      if (fh) begin
         ev_tag = "R7"; m_src = 0; m_div = 3; m_en = (m_en | 4'b0001) & ~4'b0100; m_pv = 0;
      end else if (wh) begin
         ev_tag = "R6"; m_src = 0; m_en = m_en | 4'b0001; m_pv = 0;
      end else if (go) begin
         ev_tag = "R4";
         m_div = dec_div(cfg_div);
         m_en  = cfg_osc_en | (4'b0001 << m_src) | (4'b0001 << cfg_src);
         m_pv  = (int'(cfg_src) != m_src);
         m_pt  = int'(cfg_src);
         m_fw  = cfg_fast_wake;
      end else if (m_pv && osc_rdy[m_pt]) begin
         ev_tag = "R4"; m_src = m_pt; m_pv = 0;
      end else begin
         ev_tag = "R1";
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all();
      idle();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; idle(); cfg_src = 0; cfg_div = 0; cfg_osc_en = 0;
      cfg_fast_wake = 0; osc_rdy = 4'b0000;
      m_src = 0; m_div = 3; m_en = 4'b0001; m_pv = 0; m_pt = 0; m_fw = 0; ev_tag = "R2";
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R2 reset state
      check("R2 source", int'(mclk_src), 0);
      check("R2 prescaler", int'(rc_div_sel), 3);
      check("R2 enables", int'(osc_en), 1);
      check("R2 wait state", int'(flash_ws), 0);

      // R3 every prescaler code
      for (int c = 0; c < 8; c++) begin
         wr(0, c, 4'b0001, 0); tick();
         check("R3 code", int'(rc_div_sel), (c > 3) ? 3 : c);
      end

      // R4 crystal pending until ready
      wr(2, 1, 4'b0001, 0); tick();
      check("R4 pending hold", int'(mclk_src), 0);
      osc_rdy = 4'b0011; tick();
      check("R4 not ready", int'(mclk_src), 0);
      osc_rdy = 4'b0100; tick();
      check("R4 switched", int'(mclk_src), 2);
      check("R9 crystal ws", int'(flash_ws), 1);

      // R5 disabling active source ignored
      wr(2, 1, 4'b0000, 0); tick();
      check("R5 active kept", int'(osc_en), 4'b0100);

      // R8 failure with a write in the same cycle
      wr(3, 0, 4'b1111, 0); xtal_fail = 1; tick();
      check("R8 write dropped", int'(osc_en), 4'b0001);
      check("R7 fallback src", int'(mclk_src), 0);
      check("R7 fallback div", int'(rc_div_sel), 3);

      // R7 failure without crystal involvement
      xtal_fail = 1; tick();
      check("R7 no effect", int'(rc_div_sel), 3);

      // R6 wakeup ignored without option
      osc_rdy = 4'b0010; wr(1, 2, 4'b0010, 0); tick(); tick();
      check("R4 slow active", int'(mclk_src), 1);
      wake_evt = 1; tick();
      check("R6 wake ignored", int'(mclk_src), 1);
      wr(1, 2, 4'b0010, 1); tick();
      wake_evt = 1; tick();
      check("R6 wake taken", int'(mclk_src), 0);
      check("R6 div kept", int'(rc_div_sel), 2);

      // R9 user clock needs no wait state
      osc_rdy = 4'b1000; wr(3, 0, 4'b1000, 0); tick(); tick();
      check("R9 user clock src", int'(mclk_src), 3);
      check("R9 user clock ws", int'(flash_ws), 0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         osc_rdy = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 3) == 0)
            wr($urandom_range(0, 3), $urandom_range(0, 7),
               4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
         wake_evt  = ($urandom_range(0, 19) == 0);
         xtal_fail = ($urandom_range(0, 19) == 0);
         tick();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule